// File: doc/BRIEF.md
# Charge-then-Listen Transponder Capture Sequencer

This block runs one complete read of a low-frequency transponder from a single start pulse. It first wipes the capture memory by writing zero to every word address. It then raises a modulation-enable output for a fixed number of system clocks, so that the antenna driver energises the tag. When that charge window closes, the modulation output falls and stays low while the block listens.

While listening, a sample strobe is derived from the system clock. On each strobe one bit is taken from a one-bit comparator input. Bits are packed into 32-bit words, with the earliest bit in the top position. Each completed word is written once to a word-addressed memory port. After the configured number of words the block stops writing, drops busy and raises done. Done stays set until the next start.

All timing is set by parameters, so a simulation can shorten the charge window and the word count. By default the charge lasts 2,400,000 clocks, which is 50 ms at 48 MHz. The capture holds 5000 words and the strobe divisor is 12.

Top module: `tag_capture_seq`

## Requirements
- R1: After reset the block is idle: busy, done, modulation enable and memory write enable are all 0.
- R2: A start pulse while idle raises busy on the next cycle. The block then issues exactly WORD_COUNT consecutive single-cycle writes of data 0 to addresses 0, 1, … WORD_COUNT-1, before the modulation enable rises.
- R3: Right after the last clearing write, the modulation enable is 1 for exactly CHARGE_CYCLES consecutive cycles. No memory write happens during that time.
- R4: Once the charge window ends, the modulation enable stays 0 for the rest of the capture and while done.
- R5: In listen mode one comparator bit is sampled every 2×SAMPLE_DIV clocks. The first sample falls on the last clock of the first 2×SAMPLE_DIV-clock window after the modulation enable falls. The final word is therefore written in the cycle that comes WORD_COUNT×32×2×SAMPLE_DIV cycles after the first listen cycle.
- R6: Within a word, the first sampled bit lands in bit 31 and the 32nd sampled bit in bit 0.
- R7: Each captured word is written with one single-cycle write enable. Capture addresses start at 0 and increase by one per word.
- R8: After WORD_COUNT captured words the block writes nothing more. Done rises in the cycle after the last write, and busy falls with it.
- R9: A start pulse while busy is ignored: the charge window keeps its length and the capture completes unchanged.
- R10: Done stays 1 until a new start. A start while done clears done and begins a new acquisition from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, acted on only when not busy |
| comp_i | input | 1 | Comparator bit from the antenna front end |
| mod_en_o | output | 1 | High while the antenna is driven to charge the tag |
| mem_we_o | output | 1 | Capture memory write strobe |
| mem_addr_o | output | ADDR_W | Capture memory word address |
| mem_wdata_o | output | WORD_W | Capture memory write data |
| busy_o | output | 1 | Acquisition in progress |
| done_o | output | 1 | Acquisition finished, held until next start |

## Verification
The bench holds each comparator value constant for one whole strobe window. Any off-by-one in the strobe period therefore shows up as corrupted words or as a final write in the wrong cycle. A design that shifts bits LSB-first, or slips one bit between words, writes data that differs from the bench's reference words. A charge counter that is off by one changes the measured length of the modulation window. A design that acts on a start pulse during the charge or listen phase shows a restarted clear or a stretched charge. A design that keeps running after the last word shows extra writes in the idle cycles that the bench watches after done.

// File: rtl/tag_capture_pkg.sv
package tag_capture_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CLEAR  = 3'd1,
        ST_CHARGE = 3'd2,
        ST_LISTEN = 3'd3,
        ST_DONE   = 3'd4
    } cap_state_e;

endpackage

// File: rtl/tag_sample_tick.sv
module tag_sample_tick #(
    parameter int SAMPLE_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int PERIOD = 2 * SAMPLE_DIV;
    localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_regs_t;

    tick_regs_t r_d, r_q;

    assign tick_o = run_i && (r_q.cnt == LAST);

    always_comb begin
        r_d = r_q;
        if (!run_i) begin
            r_d.cnt = '0;
        end else if (tick_o) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // two strobes can never be adjacent because the period is at least 2
    assert_tick_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/tag_bit_packer.sv
module tag_bit_packer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              tick_i,
    input  logic              bit_i,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int BW = $clog2(WORD_W);
    localparam logic [BW-1:0] BIT_LAST = BW'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic [BW-1:0]     bcnt;
        logic              valid;
    } pack_regs_t;

    pack_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (clr_i) begin
            r_d.bcnt = '0;
        end else if (tick_i) begin
            r_d.shift = {r_q.shift[WORD_W-2:0], bit_i};
            if (r_q.bcnt == BIT_LAST) begin
                r_d.bcnt  = '0;
                r_d.valid = 1'b1;
            end else begin
                r_d.bcnt = r_q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign word_valid_o = r_q.valid;
    assign word_o       = r_q.shift;

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    assert_clear_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !word_valid_o);

endmodule

// File: rtl/tag_capture_fsm.sv
module tag_capture_fsm
    import tag_capture_pkg::*;
#(
    parameter int WORD_COUNT    = 5000,
    parameter int CHARGE_CYCLES = 2400000,
    parameter int ADDR_W        = (WORD_COUNT > 1) ? $clog2(WORD_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              word_valid_i,
    output logic              clearing_o,
    output logic              charging_o,
    output logic              listening_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int CCW = (CHARGE_CYCLES > 1) ? $clog2(CHARGE_CYCLES) : 1;
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(WORD_COUNT - 1);
    localparam logic [CCW-1:0]    CHG_LAST  = CCW'(CHARGE_CYCLES - 1);

    typedef struct packed {
        cap_state_e        st;
        logic [ADDR_W-1:0] widx;
        logic [CCW-1:0]    ccnt;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.st   = ST_CLEAR;
                    r_d.widx = '0;
                end
            end
            ST_CLEAR: begin
                if (r_q.widx == ADDR_LAST) begin
                    r_d.st   = ST_CHARGE;
                    r_d.widx = '0;
                    r_d.ccnt = '0;
                end else begin
                    r_d.widx = r_q.widx + 1'b1;
                end
            end
            ST_CHARGE: begin
                if (r_q.ccnt == CHG_LAST) begin
                    r_d.st = ST_LISTEN;
                end else begin
                    r_d.ccnt = r_q.ccnt + 1'b1;
                end
            end
            ST_LISTEN: begin
                if (word_valid_i) begin
                    if (r_q.widx == ADDR_LAST) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.widx = r_q.widx + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, widx: '0, ccnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign clearing_o  = (r_q.st == ST_CLEAR);
    assign charging_o  = (r_q.st == ST_CHARGE);
    assign listening_o = (r_q.st == ST_LISTEN);
    assign busy_o      = clearing_o || charging_o || listening_o;
    assign done_o      = (r_q.st == ST_DONE);
    assign addr_o      = r_q.widx;

    assert_addr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.widx <= ADDR_LAST);

    assert_charge_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (charging_o && r_q.ccnt != CHG_LAST) |=> charging_o);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (charging_o && start_i) |=> (charging_o || listening_o));

    assert_done_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

endmodule

// File: rtl/tag_capture_seq.sv
module tag_capture_seq #(
    parameter int WORD_W        = 32,
    parameter int WORD_COUNT    = 5000,
    parameter int CHARGE_CYCLES = 2400000,
    parameter int SAMPLE_DIV    = 12,
    parameter int ADDR_W        = (WORD_COUNT > 1) ? $clog2(WORD_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              comp_i,
    output logic              mod_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              busy_o,
    output logic              done_o
);
    logic              clearing, charging, listening;
    logic              tick, word_valid;
    logic [WORD_W-1:0] word;
    logic [ADDR_W-1:0] addr;

    tag_capture_fsm #(
        .WORD_COUNT   (WORD_COUNT),
        .CHARGE_CYCLES(CHARGE_CYCLES),
        .ADDR_W       (ADDR_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .word_valid_i(word_valid),
        .clearing_o  (clearing),
        .charging_o  (charging),
        .listening_o (listening),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .addr_o      (addr)
    );

    tag_sample_tick #(
        .SAMPLE_DIV(SAMPLE_DIV)
    ) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (listening),
        .tick_o(tick)
    );

    tag_bit_packer #(
        .WORD_W(WORD_W)
    ) i_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (!listening),
        .tick_i      (tick),
        .bit_i       (comp_i),
        .word_valid_o(word_valid),
        .word_o      (word)
    );

    assign mod_en_o    = charging;
    assign mem_we_o    = clearing || (listening && word_valid);
    assign mem_addr_o  = addr;
    assign mem_wdata_o = clearing ? '0 : word;

    assert_no_write_in_charge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mod_en_o |-> !mem_we_o);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !mem_we_o));

    assert_mod_off_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mod_en_o);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

endmodule

// File: tb/test_tag_capture_seq.sv
module test_tag_capture_seq;
    localparam int WC     = 4;
    localparam int CHG    = 40;
    localparam int DIV    = 2;
    localparam int WW     = 32;
    localparam int AW     = 2;
    localparam int WIN    = 2 * DIV;
    localparam int LIMIT  = 4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          comp_i = 1'b0;
    logic          mod_en_o, mem_we_o, busy_o, done_o;
    logic [AW-1:0] mem_addr_o;
    logic [WW-1:0] mem_wdata_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tag_capture_seq #(
        .WORD_W(WW), .WORD_COUNT(WC), .CHARGE_CYCLES(CHG), .SAMPLE_DIV(DIV)
    ) i_tag_capture_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .comp_i(comp_i),
        .mod_en_o(mod_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit pat_bit(input int pat, input int k);
        case (pat)
            0: return (k % 3) == 0;
            1: return (k % 2) == 1;
            2: return 1'b1;
            default: return ((k * 7 + (k >> 3)) >> 2) % 2 == 1;
        endcase
    endfunction

    function automatic logic [WW-1:0] exp_word(input int pat, input int w);
        logic [WW-1:0] v = '0;
        for (int j = 0; j < WW; j++) v[WW-1-j] = pat_bit(pat, w * WW + j);
        return v;
    endfunction

    // full acquisition; poke != 0 pulses start during charge and listen
    task automatic run_capture(input int pat, input bit poke, input string tag);
        int clr_wr = 0, wr = 0, mod_cyc = 0, lcyc = -1, last_wr_l = -1;
        bit seen_mod = 0, mod_late = 0, bad_clear = 0, bad_order = 0;
        bit wr_in_chg = 0, busy_drop = 0, finished = 0;
        logic [WW-1:0] got [WC];
        for (int w = 0; w < WC; w++) got[w] = '0;
        @(negedge clk);
        start_i = 1'b1;
        for (int c = 0; c < LIMIT; c++) begin
            @(negedge clk);
            if (c == 0) start_i = 1'b0;
            if (poke) start_i = (c == 10 || c == 100);
            if (done_o) begin
                finished = 1;
                break;
            end
            if (!busy_o) busy_drop = 1;
            if (mod_en_o) begin
                mod_cyc++;
                seen_mod = 1;
                if (lcyc >= 0) mod_late = 1;
                if (mem_we_o) wr_in_chg = 1;
            end else if (seen_mod) begin
                lcyc++;
            end
            if (mem_we_o && !mod_en_o) begin
                if (!seen_mod) begin
                    if (mem_wdata_o != '0 || int'(mem_addr_o) != clr_wr) bad_clear = 1;
                    clr_wr++;
                end else begin
                    if (wr < WC) begin
                        if (int'(mem_addr_o) != wr) bad_order = 1;
                        got[wr] = mem_wdata_o;
                    end
                    wr++;
                    last_wr_l = lcyc;
                end
            end
            comp_i = (lcyc >= 0) ? pat_bit(pat, lcyc / WIN) : 1'b0;
        end
        start_i = 1'b0;
        check(finished, "R8", {tag, " done reached"}, finished, 1);
        check(!busy_drop, "R2", {tag, " busy held during run"}, busy_drop, 0);
        check(clr_wr == WC && !bad_clear, "R2", {tag, " clear writes"}, clr_wr, WC);
        check(mod_cyc == CHG, "R3", {tag, " charge length"}, mod_cyc, CHG);
        check(!wr_in_chg, "R3", {tag, " no write while charging"}, wr_in_chg, 0);
        check(!mod_late, "R4", {tag, " modulation off while listening"}, mod_late, 0);
        check(last_wr_l == WC * WW * WIN, "R5", {tag, " final write cycle"},
              last_wr_l, WC * WW * WIN);
        check(wr == WC && !bad_order, "R7", {tag, " capture write count/order"}, wr, WC);
        for (int w = 0; w < WC; w++)
            check(got[w] == exp_word(pat, w), "R6", {tag, " word data"},
                  got[w], exp_word(pat, w));
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (mem_we_o || mod_en_o || busy_o || !done_o) begin
                check(0, "R8", {tag, " idle after done"},
                      {mem_we_o, mod_en_o, busy_o, done_o}, 4'b0001);
                break;
            end
        end
        check(done_o && !busy_o, "R10", {tag, " done held"}, {done_o, busy_o}, 2'b10);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check({busy_o, done_o, mod_en_o, mem_we_o} == 4'b0, "R1", "reset outputs",
              {busy_o, done_o, mod_en_o, mem_we_o}, 0);
    endtask

    task automatic test_restart_clears_done();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o && busy_o && mem_we_o && mem_addr_o == '0, "R10",
              "restart clears done", {done_o, busy_o, mem_we_o}, 3'b011);
        wait (done_o == 1'b1);
    endtask

    initial begin
        #(LIMIT * 20 * 4);
        check(0, "R8", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_reset();
        run_capture(0, 1'b0, "pattern0");
        run_capture(1, 1'b1, "busy start ignored R9");
        run_capture(2, 1'b0, "all ones");
        test_restart_clears_done();
        run_capture(3, 1'b0, "mixed");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule